// File: doc/BRIEF.md
# 64-bit Compare Timer with Periodic Reload

A free-running 64-bit up-counter with one 64-bit comparator and a level interrupt output. Software reaches it through a plain 32-bit register port: an address, a write strobe, write data and registered read data. The counter and the comparator each appear as two 32-bit words. Four control bits start the count, arm the comparison, unmask the interrupt and turn on periodic reload. A sticky event flag records compare hits and is cleared when software writes a one to it.

The comparison is "greater than or equal", so a comparator value that the counter has already passed fires at once instead of waiting for the count to wrap. In periodic mode every hit adds a programmable 32-bit step to the comparator, so hits repeat at that interval while the counter keeps running. An internal arm bit lets each comparator value raise the flag only once. A cleared flag therefore stays clear until the comparator moves, either through a register write or through a periodic step. Software reads a coherent 64-bit count by reading the high word, then the low word, then the high word again, and retrying if the two high reads differ.

Top module: `cmp_timer64`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While the run bit is 0, writes to offset 0x00 (count bits 31:0) and offset 0x04 (count bits 63:32) load that half, and a read returns the loaded value.
- R3: While the run bit is 1, the count rises by exactly one each clock, carries from the low word into the high word, and keeps rising after a compare hit.
- R4: While the run bit is 1, writes to either count half are ignored.
- R5: With the compare bit set and the arm bit set, the edge after the count reaches or passes the comparator sets status bit 0. A comparator value below the current count fires at once.
- R6: Writing 1 to status bit 0 (offset 0x0C) clears the flag, and writing 0 leaves it unchanged. If a hit and a clear arrive on the same edge, the hit wins.
- R7: Each comparator value sets the flag at most once. After a clear the flag stays low until the comparator is written or steps forward.
- R8: `irq` is high exactly while the flag is set and the interrupt bit is 1.
- R9: With the periodic bit set, each hit adds the step register (offset 0x18, zero-extended) to the comparator (0x10 low word, 0x14 high word). A write to the step register leaves the comparator unchanged.
- R10: Read data is registered: the value of the register addressed at one edge is on `bus_rdata` until the next edge. Control at offset 0x08 holds run (bit 0), compare (bit 1), interrupt (bit 2) and periodic (bit 3).
- R11: Reads of any other offset, including 0x1C, return zero, and writes to them change nothing. Control bits above bit 3 are dropped and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Registered read data |
| irq | output | 1 | Level interrupt: flag AND interrupt bit |

## Verification
The assertions check on every cycle that a running count steps by one, that a stopped count stays put unless a half is written, that the flag only rises after an enabled comparison had already been met, that the flag holds until it is cleared, that a periodic hit moves the comparator by the step, and that unmapped offsets read zero. The bench scenarios show what a single property cannot: the carry into the high word, the ignored writes while running, the single shot per comparator value and its re-arming by a rewrite, the interrupt mask, and the comparator sequence 10, 35, 135 under periodic reload. The bench's cycle-level model also checks read data and `irq` on every clock.

// File: rtl/ct_pkg.sv
package ct_pkg;
   localparam int OFS_CNT_LO = 'h00;
   localparam int OFS_CNT_HI = 'h04;
   localparam int OFS_CTRL   = 'h08;
   localparam int OFS_STAT   = 'h0C;
   localparam int OFS_CMP_LO = 'h10;
   localparam int OFS_CMP_HI = 'h14;
   localparam int OFS_STEP   = 'h18;
   localparam int CTL_BITS   = 4;

   typedef struct packed {
      logic periodic;  // bit 3
      logic irq_en;    // bit 2
      logic cmp_en;    // bit 1
      logic run;       // bit 0
   } ctl_t;
endpackage

// File: rtl/ct_counter.sv
module ct_counter #(
   parameter int BUS_W = 32,
   parameter int NHALF = 2,
   localparam int CNT_W = BUS_W * NHALF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [NHALF-1:0] half_wr,
   input  logic [BUS_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      cnt_nxt = cnt;
      if (run) begin
         cnt_nxt = cnt + CNT_W'(1);
      end else begin
         for (int h = 0; h < NHALF; h++) begin
            if (half_wr[h]) cnt_nxt[h*BUS_W +: BUS_W] = wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end
endmodule

// File: rtl/ct_compare.sv
module ct_compare #(
   parameter int BUS_W = 32,
   parameter int NHALF = 2,
   localparam int CNT_W = BUS_W * NHALF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cmp_en,
   input  logic             periodic,
   input  logic [NHALF-1:0] cmp_wr,
   input  logic             step_wr,
   input  logic             clr_req,
   input  logic [BUS_W-1:0] wdata,
   output logic [CNT_W-1:0] cmp,
   output logic [BUS_W-1:0] step,
   output logic             flag
);
   logic             armed;
   logic             hit;
   logic [CNT_W-1:0] cmp_nxt;
   logic             armed_nxt;

   assign hit = cmp_en && armed && (cnt >= cmp);

   always_comb begin
      cmp_nxt   = cmp;
      armed_nxt = armed;
      if (|cmp_wr) begin
         for (int h = 0; h < NHALF; h++) begin
            if (cmp_wr[h]) cmp_nxt[h*BUS_W +: BUS_W] = wdata;
         end
         armed_nxt = 1'b1;
      end else if (hit) begin
         if (periodic) begin
            cmp_nxt   = cmp + {{(CNT_W-BUS_W){1'b0}}, step};
            armed_nxt = 1'b1;
         end else begin
            armed_nxt = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp   <= '0;
         step  <= '0;
         armed <= 1'b0;
         flag  <= 1'b0;
      end else begin
         cmp   <= cmp_nxt;
         armed <= armed_nxt;
         if (step_wr) step <= wdata;
         if (hit)          flag <= 1'b1;
         else if (clr_req) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/ct_readmux.sv
module ct_readmux #(
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 5,
   localparam int CNT_W = 2 * BUS_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [CNT_W-1:0]        cnt,
   input  logic [CNT_W-1:0]        cmp,
   input  logic [BUS_W-1:0]        step,
   input  logic [ct_pkg::CTL_BITS-1:0] ctl,
   input  logic                    flag,
   output logic [BUS_W-1:0]        rdata
);
   import ct_pkg::*;
   logic [BUS_W-1:0] sel;

   always_comb begin
      case (addr)
         ADDR_W'(OFS_CNT_LO): sel = cnt[BUS_W-1:0];
         ADDR_W'(OFS_CNT_HI): sel = cnt[CNT_W-1:BUS_W];
         ADDR_W'(OFS_CTRL):   sel = {{(BUS_W-CTL_BITS){1'b0}}, ctl};
         ADDR_W'(OFS_STAT):   sel = {{(BUS_W-1){1'b0}}, flag};
         ADDR_W'(OFS_CMP_LO): sel = cmp[BUS_W-1:0];
         ADDR_W'(OFS_CMP_HI): sel = cmp[CNT_W-1:BUS_W];
         ADDR_W'(OFS_STEP):   sel = step;
         default:             sel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= sel;
   end
endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64 #(
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);
   import ct_pkg::*;
   localparam int NHALF = 2;
   localparam int CNT_W = NHALF * BUS_W;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("cmp_timer64: ADDR_W must reach offset 0x18");
   end
   if (BUS_W < CTL_BITS) begin : g_bad_bus
      $error("cmp_timer64: BUS_W too narrow for control bits");
   end

   ctl_t             ctl_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cmp_q;
   logic [BUS_W-1:0] step_q;
   logic             flag_q;
   logic [NHALF-1:0] cnt_wr;
   logic [NHALF-1:0] cmp_wr;
   logic             ctl_wr, step_wr, clr_req;

   function automatic logic hit_ofs(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign cnt_wr  = {bus_we && hit_ofs(bus_addr, OFS_CNT_HI), bus_we && hit_ofs(bus_addr, OFS_CNT_LO)};
   assign cmp_wr  = {bus_we && hit_ofs(bus_addr, OFS_CMP_HI), bus_we && hit_ofs(bus_addr, OFS_CMP_LO)};
   assign ctl_wr  = bus_we && hit_ofs(bus_addr, OFS_CTRL);
   assign step_wr = bus_we && hit_ofs(bus_addr, OFS_STEP);
   assign clr_req = bus_we && hit_ofs(bus_addr, OFS_STAT) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_wr) ctl_q <= ctl_t'(bus_wdata[CTL_BITS-1:0]);
   end

   ct_counter #(.BUS_W(BUS_W), .NHALF(NHALF)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .half_wr(cnt_wr),
      .wdata(bus_wdata), .cnt(cnt_q)
   );

   ct_compare #(.BUS_W(BUS_W), .NHALF(NHALF)) u_cmp (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .cmp_en(ctl_q.cmp_en),
      .periodic(ctl_q.periodic), .cmp_wr(cmp_wr), .step_wr(step_wr),
      .clr_req(clr_req), .wdata(bus_wdata), .cmp(cmp_q), .step(step_q),
      .flag(flag_q)
   );

   ct_readmux #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .cnt(cnt_q), .cmp(cmp_q),
      .step(step_q), .ctl(ctl_q), .flag(flag_q), .rdata(bus_rdata)
   );

   assign irq = flag_q && ctl_q.irq_en;
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 5,
   localparam int CNT_W = 2 * BUS_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [BUS_W-1:0]  rdata,
   input logic [3:0]        ctl,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cmp,
   input logic [BUS_W-1:0]  step,
   input logic              flag,
   input logic [1:0]        cnt_wr,
   input logic [1:0]        cmp_wr,
   input logic              clr_req
);
   logic mapped;
   assign mapped = (addr <= ADDR_W'('h18)) && (addr[1:0] == 2'b00);

   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      ctl[0] |=> cnt == $past(cnt) + CNT_W'(1));

   a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[0] && cnt_wr == 2'b00) |=> $stable(cnt));

   a_r5_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ($past(ctl[1]) && $past(cnt >= cmp)));

   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_req) |=> flag);

   a_r9_periodic_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag) && $past(ctl[3]) && $past(cmp_wr) == 2'b00)
         |-> cmp == $past(cmp) + {{(CNT_W-BUS_W){1'b0}}, $past(step)});

   a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |=> rdata == '0);
endmodule

bind cmp_timer64 ct_checker #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rdata(bus_rdata),
   .ctl(ctl_q), .cnt(cnt_q), .cmp(cmp_q), .step(step_q), .flag(flag_q),
   .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .clr_req(clr_req)
);

// File: tb/tb_cmp_timer64.sv
module tb_cmp_timer64;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   cmp_timer64 dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   // ---- behavioural reference model ----
   logic [63:0] m_cnt, m_cmp;
   logic [31:0] m_step, m_rd;
   logic [3:0]  m_ctl;
   logic        m_flag, m_armed, m_hit;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_cmp = 0; m_step = 0; m_rd = 0; m_ctl = 0;
         m_flag = 0; m_armed = 0;
      end else begin
         case (bus_addr)
            5'h00: m_rd = m_cnt[31:0];
            5'h04: m_rd = m_cnt[63:32];
            5'h08: m_rd = {28'd0, m_ctl};
            5'h0C: m_rd = {31'd0, m_flag};
            5'h10: m_rd = m_cmp[31:0];
            5'h14: m_rd = m_cmp[63:32];
            5'h18: m_rd = m_step;
            default: m_rd = 0;
         endcase
         m_hit = m_ctl[1] && m_armed && (m_cnt >= m_cmp);
         if (m_hit) m_flag = 1;
         else if (bus_we && bus_addr == 5'h0C && bus_wdata[0]) m_flag = 0;
         if (bus_we && (bus_addr == 5'h10 || bus_addr == 5'h14)) begin
            if (bus_addr == 5'h10) m_cmp[31:0] = bus_wdata;
            else                   m_cmp[63:32] = bus_wdata;
            m_armed = 1;
         end else if (m_hit) begin
            if (m_ctl[3]) m_cmp = m_cmp + {32'd0, m_step};
            else          m_armed = 0;
         end
         if (m_ctl[0]) m_cnt = m_cnt + 1;
         else if (bus_we && bus_addr == 5'h00) m_cnt[31:0] = bus_wdata;
         else if (bus_we && bus_addr == 5'h04) m_cnt[63:32] = bus_wdata;
         if (bus_we && bus_addr == 5'h18) m_step = bus_wdata;
         if (bus_we && bus_addr == 5'h08) m_ctl = bus_wdata[3:0];
      end
   end

   // per-cycle comparison against the model (R10 read path, R8 interrupt)
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         n_checks++;
         if (bus_rdata !== m_rd || irq !== (m_flag && m_ctl[2])) begin
            n_fail++;
            $display("FAIL R10/R8 model: rdata=%h irq=%b expected rdata=%h irq=%b",
                     bus_rdata, irq, m_rd, m_flag && m_ctl[2]);
         end
      end
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] v);
      bus_addr = a; bus_we = 1'b0;
      @(negedge clk);
      v = bus_rdata;
   endtask

   task automatic wait_irq(input int lim, input string tag);
      int k = 0;
      while (irq !== 1'b1 && k < lim) begin
         @(negedge clk);
         k++;
      end
      chk(tag, {31'd0, irq}, 32'd1);
   endtask

   logic [31:0] v, h1, h2;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         rd(5'(a * 4), v);
         chk("R1 reset register", v, 32'd0);
      end
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);

      // R2: load count while stopped
      wr(5'h00, 32'hFFFF_FFF0);
      wr(5'h04, 32'h0000_0001);
      rd(5'h00, v); chk("R2 count low load", v, 32'hFFFF_FFF0);
      rd(5'h04, v); chk("R2 count high load", v, 32'h1);

      // R3: run and carry into the high word
      wr(5'h08, 32'h1);
      repeat (30) @(negedge clk);
      rd(5'h04, h1); rd(5'h00, v); rd(5'h04, h2);
      chk("R3 carry to high word", h1, 32'h2);
      chk("R3 coherent high reads", h2, h1);

      // R4: writes while running are ignored
      wr(5'h00, 32'h0);
      wr(5'h04, 32'h7);
      rd(5'h04, v); chk("R4 high write ignored", v, 32'h2);
      rd(5'h00, v); chk("R4 low write ignored", {31'd0, v > 32'd16}, 32'd1);

      // R5/R8: greater-or-equal compare, interrupt
      wr(5'h08, 32'h0);
      wr(5'h00, 32'h0);
      wr(5'h04, 32'h0);
      rd(5'h00, v); chk("R2 reload zero", v, 32'h0);
      wr(5'h10, 32'd20);
      wr(5'h14, 32'd0);
      wr(5'h08, 32'h7);
      rd(5'h0C, v); chk("R5 flag not yet", v, 32'd0);
      wait_irq(100, "R8 irq on hit");
      rd(5'h0C, v); chk("R5 flag set", v, 32'd1);
      rd(5'h00, v); chk("R3 keeps counting after hit", {31'd0, v > 32'd20}, 32'd1);

      // R6: write-one-to-clear
      wr(5'h0C, 32'h0);
      rd(5'h0C, v); chk("R6 write zero no effect", v, 32'd1);
      wr(5'h0C, 32'h1);
      rd(5'h0C, v); chk("R6 write one clears", v, 32'd0);
      repeat (10) @(negedge clk);
      rd(5'h0C, v); chk("R7 no refire same comparator", v, 32'd0);
      chk("R7 irq stays low", {31'd0, irq}, 32'd0);

      // R5/R7: comparator below count fires at once after rewrite
      wr(5'h10, 32'd5);
      repeat (3) @(negedge clk);
      rd(5'h0C, v); chk("R7 rearm on comparator write", v, 32'd1);

      // R8: mask
      wr(5'h08, 32'h3);
      chk("R8 irq masked", {31'd0, irq}, 32'd0);
      wr(5'h08, 32'h7);
      chk("R8 irq unmasked", {31'd0, irq}, 32'd1);
      wr(5'h0C, 32'h1);

      // R9: periodic reload
      wr(5'h08, 32'h0);
      wr(5'h00, 32'h0);
      wr(5'h04, 32'h0);
      wr(5'h10, 32'd10);
      wr(5'h14, 32'd0);
      wr(5'h18, 32'd25);
      wr(5'h08, 32'hF);
      wait_irq(100, "R9 first periodic hit");
      rd(5'h10, v); chk("R9 comparator stepped", v, 32'd35);
      wr(5'h18, 32'd100);
      rd(5'h10, v); chk("R9 step write leaves comparator", v, 32'd35);
      rd(5'h18, v); chk("R10 step readback", v, 32'd100);
      wr(5'h0C, 32'h1);
      wait_irq(100, "R9 second periodic hit");
      rd(5'h10, v); chk("R9 second step", v, 32'd135);
      rd(5'h14, v); chk("R9 comparator high", v, 32'd0);

      // R11: unmapped offsets and control upper bits
      wr(5'h1C, 32'hDEAD_BEEF);
      rd(5'h1C, v); chk("R11 unmapped reads zero", v, 32'd0);
      rd(5'h18, v); chk("R11 unmapped write no effect", v, 32'd100);
      wr(5'h08, 32'hFFFF_FFF0);
      rd(5'h08, v); chk("R11 control upper bits dropped", v, 32'd0);
      rd(5'h00, h1);
      repeat (4) @(negedge clk);
      rd(5'h00, h2);
      chk("R4 count stopped", h2, h1);

      repeat (5) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule